// File: doc/BRIEF.md
# Multi-Port GPIO Register Bank

The block holds the data and direction registers for four general-purpose I/O ports: three 8-bit ports (A, B and D) and one 3-bit port (E). It sits on a byte-wide register bus with a write strobe and a combinational read path. It drives a registered output value and output enable for every pin. Reads of a data register do not return the stored value. They return the pin level after a two-flop input sampler, so software sees what is actually on the wire.

Port D uses the opposite direction polarity: a cleared direction bit makes its pin an output. Because of this, a reset leaves ports A, B and E as inputs and port D driving zeros. A byte-order strap, captured only while reset is held, reverses the byte lanes inside each 32-bit word of the address map. Any of three active-low resets (power-on, user, power-fail) clears every register.

Top module: `gpio_bank_top`

## Requirements
- R1: While any reset input is low, and after it is released, every data and direction bit reads as zero. pinOut* are then 0, pinOeA, pinOeB and pinOeE are 0, and pinOeD is 8'hFF.
- R2: For ports A, B and E, pinOe equals the stored direction bits (1 = output), and pinOut equals the stored data bits.
- R3: For port D, pinOeD is the bitwise inverse of the stored direction bits (0 = output), and pinOutD equals the stored data bits.
- R4: Reading a data register returns the pin input level as it was two clock edges earlier, regardless of the value last written.
- R5: Reading a direction register returns the stored direction bits.
- R6: With the strap low at reset (little-endian), data registers sit at 0x00 (A), 0x01 (B) and 0x03 (D), and direction registers at 0x40, 0x41 and 0x43. Port E data is at 0x80 and its direction at 0xC0.
- R7: With the strap high at reset (big-endian), the byte lane within each word is reversed. A is at 0x03, B at 0x02 and D at 0x00; the direction registers are at 0x43, 0x42 and 0x40; port E is at 0x83 and 0xC3.
- R8: The reserved lane (0x02/0x42 little-endian, 0x01/0x41 big-endian), the other lanes of the port E words, and every other address read as zero and ignore writes.
- R9: A write lands on the clock edge that samples busWrite high. A read in the same cycle returns the pre-write value, and the new value is visible from the next cycle.
- R10: The strap is sampled only while reset is active. Changing it afterwards leaves the address map unchanged.
- R11: Each of the three reset inputs alone produces the full R1 reset state.
- R12: Port E uses only busWdata[2:0]. Its reads return zero in bits 7:3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Power-on reset, active low |
| usrRstN | input | 1 | User reset, active low |
| pwrFailRstN | input | 1 | Power-fail reset, active low |
| bigEndStrap | input | 1 | Byte-order strap, 1 = big-endian, captured during reset |
| busAddr | input | 8 | Register byte address |
| busWrite | input | 1 | Write strobe |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for busAddr (combinational) |
| pinInA | input | 8 | Port A pin levels |
| pinInB | input | 8 | Port B pin levels |
| pinInD | input | 8 | Port D pin levels |
| pinInE | input | 3 | Port E pin levels |
| pinOutA | output | 8 | Port A output values |
| pinOeA | output | 8 | Port A output enables |
| pinOutB | output | 8 | Port B output values |
| pinOeB | output | 8 | Port B output enables |
| pinOutD | output | 8 | Port D output values |
| pinOeD | output | 8 | Port D output enables |
| pinOutE | output | 3 | Port E output values |
| pinOeE | output | 3 | Port E output enables |

## Verification
Two functions can fall in the same cycle: a write to a register and a read of that same register. The bench drives both onto the bus in one cycle and samples busRdata before the edge, expecting the old direction value. After the edge it expects the new one. Pin sampling also overlaps writes to the data registers. The bench holds pins at a pattern that differs from the written data, so every data read must show the pin pattern and never the write. Full 256-address sweeps in both byte orders compare every pin output and readback against a map computed in the bench.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_A    = 3'd1,
    SEL_B    = 3'd2,
    SEL_D    = 3'd3,
    SEL_E    = 3'd4
  } portSel_e;

  // Strobes from the address decoder to the register datapath
  typedef struct packed {
    logic     wrEn;
    logic     dirBank;
    portSel_e target;
  } bankStrobe_t;

  function automatic portSel_e wideIdxSel(input int idx);
    case (idx)
      0:       return SEL_A;
      1:       return SEL_B;
      default: return SEL_D;
    endcase
  endfunction

endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic [W-1:0] asyncIn,
  output logic [W-1:0] syncOut
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    stage1  <= asyncIn;
    syncOut <= stage1;
  end
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int                ADDR_W        = 8,
  parameter logic [ADDR_W-1:0] DATA_BASE     = 'h00,
  parameter logic [ADDR_W-1:0] DIR_BASE      = 'h40,
  parameter logic [ADDR_W-1:0] EXT_DATA_BASE = 'h80,
  parameter logic [ADDR_W-1:0] EXT_DIR_BASE  = 'hC0
) (
  input  logic              clk,
  input  logic              sysRstN,
  input  logic              bigEndStrap,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  output bankStrobe_t       strobe,
  output logic              bigEndMode
);
  logic [1:0]        logLane;
  logic [ADDR_W-1:0] wordBase;

  // Strap capture: only while reset is held
  always_ff @(posedge clk) begin
    if (!sysRstN) bigEndMode <= bigEndStrap;
  end

  assign logLane  = bigEndMode ? ~busAddr[1:0] : busAddr[1:0];
  assign wordBase = {busAddr[ADDR_W-1:2], 2'b00};

  function automatic portSel_e laneToPort(input logic [1:0] lane);
    case (lane)
      2'd0:    return SEL_A;
      2'd1:    return SEL_B;
      2'd3:    return SEL_D;
      default: return SEL_NONE;
    endcase
  endfunction

  always_comb begin
    portSel_e tgt;
    logic     isDir;
    tgt   = SEL_NONE;
    isDir = 1'b0;
    if (wordBase == DATA_BASE) begin
      tgt = laneToPort(logLane);
    end else if (wordBase == DIR_BASE) begin
      tgt   = laneToPort(logLane);
      isDir = 1'b1;
    end else if (wordBase == EXT_DATA_BASE && logLane == 2'd0) begin
      tgt = SEL_E;
    end else if (wordBase == EXT_DIR_BASE && logLane == 2'd0) begin
      tgt   = SEL_E;
      isDir = 1'b1;
    end
    strobe.target  = tgt;
    strobe.dirBank = isDir;
    strobe.wrEn    = busWrite && (tgt != SEL_NONE);
  end

  // R10
  strap_hold_chk: assert property (@(posedge clk) disable iff (!sysRstN)
    $stable(bigEndMode));

  // R7
  be_lane_chk: assert property (@(posedge clk) disable iff (!sysRstN)
    (bigEndMode && busAddr == DATA_BASE) |-> strobe.target == SEL_D);
endmodule

// File: rtl/gpio_bank_dpath.sv
module gpio_bank_dpath
  import gpio_bank_pkg::*;
#(
  parameter int                   PORT_W   = 8,
  parameter int                   EXT_W    = 3,
  parameter int                   NUM_WIDE = 3,
  parameter logic [NUM_WIDE-1:0]  DIR_INV  = 3'b100
) (
  input  logic                              clk,
  input  logic                              sysRstN,
  input  bankStrobe_t                       strobe,
  input  logic [PORT_W-1:0]                 busWdata,
  output logic [PORT_W-1:0]                 busRdata,
  input  logic [NUM_WIDE-1:0][PORT_W-1:0]   pinInWide,
  input  logic [EXT_W-1:0]                  pinInExt,
  output logic [NUM_WIDE-1:0][PORT_W-1:0]   outWide,
  output logic [NUM_WIDE-1:0][PORT_W-1:0]   oeWide,
  output logic [EXT_W-1:0]                  outExt,
  output logic [EXT_W-1:0]                  oeExt
);
  localparam int PIN_W = NUM_WIDE * PORT_W + EXT_W;

  logic [NUM_WIDE-1:0][PORT_W-1:0] wideDir;
  logic [EXT_W-1:0]                extData, extDir;
  logic [PIN_W-1:0]                pinVec, syncVec;
  logic [NUM_WIDE-1:0][PORT_W-1:0] syncWide;
  logic [EXT_W-1:0]                syncExt;

  assign pinVec = {pinInExt, pinInWide};

  gpio_bank_sync #(.W(PIN_W)) uSync (
    .clk     (clk),
    .asyncIn (pinVec),
    .syncOut (syncVec)
  );

  assign syncWide = syncVec[NUM_WIDE*PORT_W-1:0];
  assign syncExt  = syncVec[PIN_W-1:NUM_WIDE*PORT_W];

  for (genvar p = 0; p < NUM_WIDE; p++) begin : g_port
    localparam portSel_e MY_SEL = wideIdxSel(p);
    logic [PORT_W-1:0] dataQ, dirQ;

    always_ff @(posedge clk or negedge sysRstN) begin
      if (!sysRstN) begin
        dataQ <= '0;
        dirQ  <= '0;
      end else if (strobe.wrEn && strobe.target == MY_SEL) begin
        if (strobe.dirBank) dirQ  <= busWdata;
        else                dataQ <= busWdata;
      end
    end

    assign outWide[p] = dataQ;
    assign wideDir[p] = dirQ;
    if (DIR_INV[p]) begin : g_inv
      assign oeWide[p] = ~dirQ;
    end else begin : g_dir
      assign oeWide[p] = dirQ;
    end
  end

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) begin
      extData <= '0;
      extDir  <= '0;
    end else if (strobe.wrEn && strobe.target == SEL_E) begin
      if (strobe.dirBank) extDir  <= busWdata[EXT_W-1:0];
      else                extData <= busWdata[EXT_W-1:0];
    end
  end

  assign outExt = extData;
  assign oeExt  = extDir;

  always_comb begin
    busRdata = '0;
    case (strobe.target)
      SEL_A: busRdata = strobe.dirBank ? wideDir[0] : syncWide[0];
      SEL_B: busRdata = strobe.dirBank ? wideDir[1] : syncWide[1];
      SEL_D: busRdata = strobe.dirBank ? wideDir[2] : syncWide[2];
      SEL_E: busRdata[EXT_W-1:0] = strobe.dirBank ? extDir : syncExt;
      default: busRdata = '0;
    endcase
  end

  // R9
  data_wr_chk: assert property (@(posedge clk) disable iff (!sysRstN)
    (strobe.wrEn && strobe.target == SEL_A && !strobe.dirBank)
      |=> outWide[0] == $past(busWdata));

  // R3
  d_dir_chk: assert property (@(posedge clk) disable iff (!sysRstN)
    (strobe.wrEn && strobe.target == SEL_D && strobe.dirBank)
      |=> oeWide[2] == ~$past(busWdata));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!sysRstN)
    !strobe.wrEn |=> $stable({outWide, wideDir, extData, extDir}));

  // R4
  sync_lat_chk: assert property (@(posedge clk) disable iff (!sysRstN)
    syncVec == $past(pinVec, 2));
endmodule

// File: rtl/gpio_bank_top.sv
module gpio_bank_top
  import gpio_bank_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter int EXT_W  = 3,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              usrRstN,
  input  logic              pwrFailRstN,
  input  logic              bigEndStrap,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic [PORT_W-1:0] busWdata,
  output logic [PORT_W-1:0] busRdata,
  input  logic [PORT_W-1:0] pinInA,
  input  logic [PORT_W-1:0] pinInB,
  input  logic [PORT_W-1:0] pinInD,
  input  logic [EXT_W-1:0]  pinInE,
  output logic [PORT_W-1:0] pinOutA,
  output logic [PORT_W-1:0] pinOeA,
  output logic [PORT_W-1:0] pinOutB,
  output logic [PORT_W-1:0] pinOeB,
  output logic [PORT_W-1:0] pinOutD,
  output logic [PORT_W-1:0] pinOeD,
  output logic [EXT_W-1:0]  pinOutE,
  output logic [EXT_W-1:0]  pinOeE
);
  localparam int NUM_WIDE = 3;

  logic                            sysRstN;
  logic                            bigEndMode;
  bankStrobe_t                     strobe;
  logic [NUM_WIDE-1:0][PORT_W-1:0] outWide, oeWide;

  assign sysRstN = porRstN & usrRstN & pwrFailRstN;

  gpio_bank_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk         (clk),
    .sysRstN     (sysRstN),
    .bigEndStrap (bigEndStrap),
    .busAddr     (busAddr),
    .busWrite    (busWrite),
    .strobe      (strobe),
    .bigEndMode  (bigEndMode)
  );

  gpio_bank_dpath #(
    .PORT_W   (PORT_W),
    .EXT_W    (EXT_W),
    .NUM_WIDE (NUM_WIDE),
    .DIR_INV  (3'b100)
  ) uDpath (
    .clk       (clk),
    .sysRstN   (sysRstN),
    .strobe    (strobe),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .pinInWide ({pinInD, pinInB, pinInA}),
    .pinInExt  (pinInE),
    .outWide   (outWide),
    .oeWide    (oeWide),
    .outExt    (pinOutE),
    .oeExt     (pinOeE)
  );

  assign pinOutA = outWide[0];
  assign pinOutB = outWide[1];
  assign pinOutD = outWide[2];
  assign pinOeA  = oeWide[0];
  assign pinOeB  = oeWide[1];
  assign pinOeD  = oeWide[2];

  // R1
  rst_oe_chk: assert property (@(posedge clk)
    !sysRstN |=> (pinOeD == '1 || !sysRstN));
endmodule

// File: tb/tb_gpio_bank_top.sv
module tb_gpio_bank_top;
  logic       clk = 1'b0;
  logic       porRstN = 1'b0, usrRstN = 1'b1, pwrFailRstN = 1'b1;
  logic       bigEndStrap = 1'b0;
  logic [7:0] busAddr = '0, busWdata = '0, busRdata;
  logic       busWrite = 1'b0;
  logic [7:0] pinInA = 8'hC3, pinInB = 8'h5A, pinInD = 8'h96;
  logic [2:0] pinInE = 3'b101;
  logic [7:0] pinOutA, pinOeA, pinOutB, pinOeB, pinOutD, pinOeD;
  logic [2:0] pinOutE, pinOeE;

  int testsRun = 0, testsFailed = 0;
  logic [7:0] mData [1:4];
  logic [7:0] mDir  [1:4];

  always #4 clk = ~clk;

  gpio_bank_top dut (.*);

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog expired");
    testsFailed++;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Target port: 0 none, 1 A, 2 B, 3 D, 4 E
  function automatic int tgtOf(input int a, input bit be, output bit isDir);
    int lane = a % 4;
    int word = a / 4;
    if (be) lane = 3 - lane;
    isDir = (word == 16 || word == 48);
    if (word == 0 || word == 16) return (lane == 0) ? 1 : (lane == 1) ? 2 : (lane == 3) ? 3 : 0;
    if ((word == 32 || word == 48) && lane == 0) return 4;
    return 0;
  endfunction

  function automatic logic [63:0] expOut();
    return {10'd0, mData[1], mDir[1], mData[2], mDir[2], mData[3], ~mDir[3],
            mData[4][2:0], mDir[4][2:0]};
  endfunction

  function automatic logic [63:0] dutOut();
    return {10'd0, pinOutA, pinOeA, pinOutB, pinOeB, pinOutD, pinOeD, pinOutE, pinOeE};
  endfunction

  task automatic clearModel();
    for (int i = 1; i <= 4; i++) begin mData[i] = '0; mDir[i] = '0; end
  endtask

  task automatic doWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWrite = 1'b1;
    @(negedge clk);
    busWrite = 1'b0;
  endtask

  task automatic doRead(input logic [7:0] a, output logic [7:0] v);
    busAddr = a;
    #1;
    v = busRdata;
  endtask

  task automatic pulseReset(input int which);
    @(negedge clk);
    case (which)
      0: porRstN = 1'b0;
      1: usrRstN = 1'b0;
      default: pwrFailRstN = 1'b0;
    endcase
    repeat (4) @(negedge clk);
    porRstN = 1'b1; usrRstN = 1'b1; pwrFailRstN = 1'b1;
    clearModel();
    @(negedge clk);
  endtask

  function automatic logic [7:0] pinOf(input int t);
    case (t)
      1: return pinInA;
      2: return pinInB;
      3: return pinInD;
      default: return {5'd0, pinInE};
    endcase
  endfunction

  task automatic sweep(input bit be, input string tag);
    logic [7:0] v;
    for (int a = 0; a < 256; a++) begin
      bit isDir;
      int t;
      logic [7:0] d = 8'((a * 37 + 11) & 255);
      t = tgtOf(a, be, isDir);
      doWrite(8'(a), d);
      if (t != 0) begin
        logic [7:0] dm = (t == 4) ? {5'd0, d[2:0]} : d;
        if (isDir) mDir[t] = dm; else mData[t] = dm;
      end
      chk({tag, " R2 R3 R8 R12 outputs"}, dutOut(), expOut());
      doRead(8'(a), v);
      if (t == 0)      chk({tag, " R8 reserved read"}, {56'd0, v}, 64'd0);
      else if (isDir)  chk({tag, " R5 R12 dir read"}, {56'd0, v}, {56'd0, mDir[t]});
      else             chk({tag, " R4 data read"}, {56'd0, v}, {56'd0, pinOf(t)});
    end
  endtask

  initial begin
    logic [7:0] v;
    clearModel();
    repeat (5) @(negedge clk);
    chk("R1 outputs during reset", dutOut(), expOut());
    porRstN = 1'b1;
    @(negedge clk);
    chk("R1 outputs after reset", dutOut(), expOut());
    doRead(8'h40, v);
    chk("R1 dir A after reset", {56'd0, v}, 64'd0);

    // R9: write and read of the same register in one cycle
    @(negedge clk);
    busAddr = 8'h41; busWdata = 8'h77; busWrite = 1'b1;
    #1;
    chk("R9 same-cycle read old", {56'd0, busRdata}, 64'd0);
    @(negedge clk);
    busWrite = 1'b0;
    #1;
    chk("R9 read new next cycle", {56'd0, busRdata}, 64'h77);
    mDir[2] = 8'h77;

    // R4: two-edge latency
    @(negedge clk);
    busAddr = 8'h00; pinInA = 8'h3C;
    @(negedge clk);
    #1;
    chk("R4 one edge still old", {56'd0, busRdata}, 64'hC3);
    @(negedge clk);
    #1;
    chk("R4 two edges new", {56'd0, busRdata}, 64'h3C);
    doWrite(8'h00, 8'hFF);
    mData[1] = 8'hFF;
    doRead(8'h00, v);
    chk("R4 read ignores stored value", {56'd0, v}, 64'h3C);

    pulseReset(0);
    sweep(1'b0, "LE R6");

    bigEndStrap = 1'b1;
    pulseReset(0);
    chk("R11 power-on reset state", dutOut(), expOut());
    sweep(1'b1, "BE R7");

    // R10: strap change outside reset has no effect
    pulseReset(0);
    bigEndStrap = 1'b0;
    repeat (2) @(negedge clk);
    doWrite(8'h00, 8'h5A);
    chk("R10 strap ignored after reset D", {56'd0, pinOutD}, 64'h5A);
    chk("R10 strap ignored after reset A", {56'd0, pinOutA}, 64'h00);

    // R11: user reset and power-fail reset each clear everything
    pulseReset(1);
    chk("R11 user reset state", dutOut(), expOut());
    doWrite(8'h00, 8'h11);
    doWrite(8'h43, 8'h0F);
    doWrite(8'hC0, 8'h07);
    chk("R6 LE after user reset", {56'd0, pinOutA}, 64'h11);
    pulseReset(2);
    chk("R11 power-fail reset state", dutOut(), expOut());

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule